// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block collects thirty level-sensitive interrupt request lines from peripherals and presents them to a processor core as a single hard-interrupt request wire plus an 8-bit vector number. Every clock, each request level is captured into a raw pending register. The pending bits are ANDed with a software-written enable mask, and the result decides whether the core is interrupted and with which vector. A lone active source gets a vector of its own. When several enabled sources are active together, the block does not choose between them. It drives one shared vector and leaves the choice of order to the interrupt handler.

Two non-maskable request inputs bypass the mask and drive a separate NMI output. Software reaches the block through a small 32-bit register bus covering 0x14 bytes. The bus gives read/write access to the enable mask and read-only views of the raw pending bits, the masked bits and the NMI input levels. An access to an offset that decodes to nothing raises a sticky error flag.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The raw pending register, read at offset 0x04 (bit i for request line i, upper two bits zero), equals the request input levels sampled at the previous clock edge.
- R2: The enable mask is read and written at offset 0x00, and only its low 30 bits are kept. Offset 0x08 reads the raw pending bits ANDed with the mask.
- R3: The hard-interrupt output is high exactly when the masked vector is non-zero. It changes on the same clock edge that updates the pending register or the mask.
- R4: When exactly one masked bit i is set, the vector output is 0x31 + i (bit 0 gives 0x31 and bit 29 gives 0x4E).
- R5: When two or more masked bits are set, the vector output is 0x30.
- R6: When the masked vector is zero, the interrupt output is low and the vector output is 0.
- R7: The NMI output is high in the cycle after either NMI input is high, and low after both are low, whatever the mask holds. Offset 0x0C reads the live NMI input levels in bits 1:0.
- R8: An access to offset 0x10, to any offset that is not a multiple of 4, or to any offset at or beyond 0x14 sets the error flag and reads as zero. The flag then stays set until reset. Writes to the read-only offsets change nothing and raise no error.
- R9: Synchronous active-low reset clears the mask, the interrupt output, the vector output, the NMI output and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 30 | Level-sensitive peripheral request lines |
| nmi_req_i | input | 2 | Non-maskable request lines |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| bus_err | output | 1 | Sticky error flag for undefined offsets |
| irq_o | output | 1 | Hard-interrupt request to the core |
| vec_o | output | 8 | Interrupt vector number |
| nmi_o | output | 1 | Non-maskable interrupt request to the core |

## Verification
The assertions check on every cycle that the interrupt wire agrees with the masked vector, that an idle controller drives vector 0, that vector 0x30 accompanies several masked bits and that a single masked bit yields the vector pointing at that same bit. They also check that the pending register trails the request lines by one edge, that the NMI output follows its inputs and that the error flag never drops by itself. Only the bench scenarios show the exact vector numbers for particular lines, the fall from a shared vector back to a single one, mask truncation, the decoding of reserved and misaligned offsets, and that reset clears the sticky flag.

// File: rtl/vic_pkg.sv
// Package vic_pkg: constants shared by the interrupt controller.
// Assumes word-granular register offsets (byte offset >> 2).
package vic_pkg;
    localparam int unsigned WORD_MASK    = 0;
    localparam int unsigned WORD_PENDING = 1;
    localparam int unsigned WORD_MASKED  = 2;
    localparam int unsigned WORD_NMI     = 3;
    localparam int unsigned WORD_LAST    = 3;
    localparam logic [7:0]  SHARED_VEC   = 8'h30;
    localparam logic [7:0]  FIRST_VEC    = 8'h31;
endpackage

// File: rtl/vic_regs.sv
// Module vic_regs: register file of the controller.
// Holds the enable mask and the sticky error flag, decodes accesses and
// muxes read data. Assumes DATA_W > NUM_SRC and one-cycle accesses.
module vic_regs #(
    parameter int unsigned NUM_SRC = 30,
    parameter int unsigned NUM_NMI = 2,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_SRC-1:0] pending_q,
    input  logic [NUM_NMI-1:0] nmi_lvl,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] mask_d,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err
);
    import vic_pkg::*;

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned PAD_S  = DATA_W - NUM_SRC;
    localparam int unsigned PAD_N  = DATA_W - NUM_NMI;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              bad_ofs;
    logic              mask_wr;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign bad_ofs = !aligned || (word > WORD_W'(WORD_LAST));
    assign mask_wr = bus_sel && bus_wr && !bad_ofs && (word == WORD_W'(WORD_MASK));

    // Next mask value, also consumed by the vector generator.
    always_comb begin
        mask_d = mask_wr ? bus_wdata[NUM_SRC-1:0] : mask_q;
    end

    // Mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // Sticky error flag for undefined offsets.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_err <= 1'b0;
        else if (bus_sel && bad_ofs) bus_err <= 1'b1;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && !bad_ofs) begin
            case (word)
                WORD_W'(WORD_MASK):    bus_rdata = {{PAD_S{1'b0}}, mask_q};
                WORD_W'(WORD_PENDING): bus_rdata = {{PAD_S{1'b0}}, pending_q};
                WORD_W'(WORD_MASKED):  bus_rdata = {{PAD_S{1'b0}}, pending_q & mask_q};
                WORD_W'(WORD_NMI):     bus_rdata = {{PAD_N{1'b0}}, nmi_lvl};
                default:               bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/vic_vecgen.sv
// Module vic_vecgen: turns the next masked vector into the registered
// request wire and vector number. Assumes FIRST_VEC + NUM_SRC fits VEC_W.
module vic_vecgen #(
    parameter int unsigned NUM_SRC = 30,
    parameter int unsigned VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] masked_d,
    output logic               irq_q,
    output logic [VEC_W-1:0]   vec_q
);
    import vic_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    logic [IDX_W-1:0] low_idx;
    logic             any_set;
    logic             multi;
    logic [VEC_W-1:0] vec_d;

    // Find the lowest set bit and detect more than one set bit.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (masked_d[i]) low_idx = IDX_W'(i);
        end
        any_set = |masked_d;
        multi   = |(masked_d & (masked_d - NUM_SRC'(1)));
    end

    // Choose the vector number.
    always_comb begin
        if (!any_set)   vec_d = '0;
        else if (multi) vec_d = VEC_W'(SHARED_VEC);
        else            vec_d = VEC_W'(FIRST_VEC) + VEC_W'(low_idx);
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= any_set;
            vec_q <= vec_d;
        end
    end
endmodule

// File: rtl/vic_nmi.sv
// Module vic_nmi: forwards the OR of the NMI inputs as a registered output.
// Assumes the inputs are already synchronous to clk.
module vic_nmi #(
    parameter int unsigned NUM_NMI = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_NMI-1:0] nmi_in,
    output logic               nmi_q
);
    // Register the combined NMI level.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= |nmi_in;
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Module vec_irq_ctrl: masked vectored interrupt controller top.
// Captures request levels, applies the enable mask, and drives the
// request wire, vector bus and NMI. Assumes synchronous inputs.
module vec_irq_ctrl #(
    parameter int unsigned NUM_SRC = 30,
    parameter int unsigned NUM_NMI = 2,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_NMI-1:0] nmi_req_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               nmi_o
);
    logic [NUM_SRC-1:0] pending_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_d;
    logic [NUM_SRC-1:0] masked_d;

    // Pending bits follow the request levels.
    always_ff @(posedge clk) begin
        pending_q <= req_i;
    end

    // Masked vector as it will stand after this edge.
    always_comb begin
        masked_d = req_i & mask_d;
    end

    vic_regs #(
        .NUM_SRC(NUM_SRC), .NUM_NMI(NUM_NMI), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pending_q(pending_q),
        .nmi_lvl(nmi_req_i), .mask_q(mask_q), .mask_d(mask_d),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    vic_vecgen #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_vecgen (
        .clk(clk), .rst_n(rst_n), .masked_d(masked_d),
        .irq_q(irq_o), .vec_q(vec_o)
    );

    vic_nmi #(.NUM_NMI(NUM_NMI)) u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_req_i), .nmi_q(nmi_o)
    );
endmodule

// File: rtl/vic_checker.sv
// Module vic_checker: cycle-by-cycle properties of vec_irq_ctrl,
// attached by bind. Observes ports plus the pending and mask registers.
module vic_checker #(
    parameter int unsigned NUM_SRC = 30,
    parameter int unsigned NUM_NMI = 2,
    parameter int unsigned VEC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] req_i,
    input logic [NUM_NMI-1:0] nmi_req_i,
    input logic [NUM_SRC-1:0] pending_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               irq_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic               nmi_o,
    input logic               bus_err
);
    import vic_pkg::*;

    logic [NUM_SRC-1:0] masked;
    assign masked = pending_q & mask_q;

    // R1: pending register trails the request lines by one edge
    p_pending_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pending_q == $past(req_i)));

    // R3: request wire agrees with the masked vector
    p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (masked != '0));

    // R4: a single masked bit gives the vector of that bit
    p_single_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(masked) == 1) |->
            ((vec_o >= VEC_W'(FIRST_VEC)) &&
             ((masked >> (vec_o - VEC_W'(FIRST_VEC))) == NUM_SRC'(1))));

    // R5: several masked bits share one vector
    p_shared_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(masked) > 1) |-> (vec_o == VEC_W'(SHARED_VEC)));

    // R6: idle controller drives vector zero
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vec_o == '0));

    // R7: NMI output follows its inputs one edge later
    p_nmi_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req_i != '0) |=> nmi_o);
    p_nmi_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req_i == '0) |=> !nmi_o);

    // R8: error flag never clears without reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> bus_err);
endmodule

bind vec_irq_ctrl vic_checker #(
    .NUM_SRC(NUM_SRC), .NUM_NMI(NUM_NMI), .VEC_W(VEC_W)
) u_vic_checker (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .nmi_req_i(nmi_req_i),
    .pending_q(pending_q), .mask_q(mask_q), .irq_o(irq_o), .vec_o(vec_o),
    .nmi_o(nmi_o), .bus_err(bus_err)
);

// File: tb/test_vec_irq_ctrl.sv
// Directed bench for vec_irq_ctrl: one task per scenario.
module test_vec_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] req_i = '0;
    logic [1:0]  nmi_req_i = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        irq_o;
    logic [7:0]  vec_o;
    logic        nmi_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .nmi_req_i(nmi_req_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_o(irq_o), .vec_o(vec_o), .nmi_o(nmi_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        step();
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R9 irq after reset", 32'(irq_o), 0);
        chk("R9 vec after reset", 32'(vec_o), 0);
        chk("R9 nmi after reset", 32'(nmi_o), 0);
        chk("R9 err after reset", 32'(bus_err), 0);
        bus_read(5'h00, d);
        chk("R9 mask after reset", d, 0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        bus_write(5'h00, 32'h0000_0020);
        req_i = 30'h20;
        step();
        chk("R3 irq single", 32'(irq_o), 1);
        chk("R4 vec line 5", 32'(vec_o), 32'h36);
        bus_read(5'h04, d);
        chk("R1 raw pending", d, 32'h20);
        bus_read(5'h08, d);
        chk("R2 masked", d, 32'h20);
        bus_write(5'h00, 32'h0);
        chk("R6 irq masked off", 32'(irq_o), 0);
        chk("R6 vec masked off", 32'(vec_o), 0);
        bus_read(5'h04, d);
        chk("R1 raw kept when masked", d, 32'h20);
        bus_read(5'h08, d);
        chk("R2 masked cleared", d, 0);
        req_i = '0;
        step();
    endtask

    task automatic t_shared();
        logic [31:0] d;
        bus_write(5'h00, 32'hFFFF_FFFF);
        bus_read(5'h00, d);
        chk("R2 mask truncated", d, 32'h3FFF_FFFF);
        req_i = 30'h0002_0008;
        step();
        chk("R5 vec shared", 32'(vec_o), 32'h30);
        chk("R3 irq shared", 32'(irq_o), 1);
        req_i = 30'h0002_0000;
        step();
        chk("R4 vec after drop to line 17", 32'(vec_o), 32'h42);
        req_i = 30'h2000_0000;
        step();
        chk("R4 vec line 29", 32'(vec_o), 32'h4E);
        req_i = 30'h1;
        step();
        chk("R4 vec line 0", 32'(vec_o), 32'h31);
        req_i = '0;
        step();
        chk("R6 vec idle", 32'(vec_o), 0);
        chk("R6 irq idle", 32'(irq_o), 0);
    endtask

    task automatic t_nmi();
        logic [31:0] d;
        bus_write(5'h00, 32'h0);
        nmi_req_i = 2'b10;
        step();
        chk("R7 nmi high", 32'(nmi_o), 1);
        chk("R7 irq untouched", 32'(irq_o), 0);
        bus_read(5'h0C, d);
        chk("R7 nmi status", d, 32'h2);
        nmi_req_i = 2'b01;
        step();
        chk("R7 nmi other line", 32'(nmi_o), 1);
        nmi_req_i = 2'b00;
        step();
        chk("R7 nmi low", 32'(nmi_o), 0);
    endtask

    task automatic t_err();
        logic [31:0] d;
        req_i = 30'h4;
        step();
        bus_write(5'h04, 32'hFFFF_FFFF);
        chk("R8 no err on read-only write", 32'(bus_err), 0);
        bus_read(5'h04, d);
        chk("R8 read-only unchanged", d, 32'h4);
        bus_read(5'h10, d);
        chk("R8 reserved reads zero", d, 0);
        chk("R8 err set", 32'(bus_err), 1);
        step(); step();
        chk("R8 err sticky", 32'(bus_err), 1);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        chk("R9 err cleared", 32'(bus_err), 0);
        bus_read(5'h02, d);
        chk("R8 misaligned err", 32'(bus_err), 1);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        bus_read(5'h18, d);
        chk("R8 beyond window err", 32'(bus_err), 1);
        req_i = '0;
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_shared();
        t_nmi();
        t_err();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule